// File: doc/BRIEF.md
# Dual Clock Post-Divider with Glitch-Free Stop

This block turns one fast source clock into two slower clock waveforms. Output A is the source divided by an even ratio between 2 and 64. A 3-bit code selects the ratio. Output B follows A, either at the same rate or at half of A's rate. Whenever both run, every rising edge of B falls on a rising edge of A.

Each output has a run input. A low run input parks that output low. A high run input lets it toggle. Each run input is first brought into the source domain. It then takes effect only at a period boundary of its own output, so stopping or starting never cuts a pulse short.

The A ratio code is also picked up only at a period boundary. A ratio change therefore never shortens a phase. An active-high reset drives both outputs low at once, without waiting for a clock edge.

Top module: `clk_postdiv`

## Requirements
- R1: The ratio code `ratio_code` = {bit2,bit1,bit0} sets the A period in source cycles: 000→2, 100→4, 010→8, 110→16, 001→32, 101→64.
- R2: The two unlisted codes, 011 and 111, both give a ratio of 64.
- R3: Output A is high for exactly ratio/2 source cycles and low for exactly ratio/2 source cycles.
- R4: With `b_half` = 0, output B has the same period and phase as A. With `b_half` = 1, B has twice A's period and stays high for one full A period.
- R5: While A is enabled, every rising edge of B is also a rising edge of A.
- R6: A low run input holds its own output low. The other output keeps running unaffected.
- R7: Stopping or starting an output never produces a truncated pulse. Every high phase has its full length.
- R8: A change on a run input shows up at its output within one output period plus four source cycles.
- R9: A new ratio code is applied only when the A counter wraps. Every high and low phase of A has the old half-ratio length or the new one.
- R10: While `rst` is high, both outputs are low. Asserting `rst` forces them low at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Active-high reset, asynchronous assertion |
| ratio_code | input | 3 | A divide-ratio code |
| b_half | input | 1 | 0: B runs at A's rate; 1: B runs at half of A's rate |
| run_a | input | 1 | High lets output A run; low parks it low |
| run_b | input | 1 | High lets output B run; low parks it low |
| clk_a | output | 1 | Divided output A |
| clk_b | output | 1 | Divided output B |

## Verification
Several properties are checked on every cycle:
- The A counter stays inside its current range.
- The latched ratio and the B phase change only at a wrap.
- Each run gate changes only at its output's boundary.
- B never rises without A while A is enabled.
- The two outputs are identical in same-rate mode.

Some behaviours can only be shown by the bench's directed scenarios:
- The actual periods and duty cycles for every code, including the fallback codes.
- The full length of the first pulse after a restart.
- The stop and start latency.
- Independence of the two stop inputs.
- The immediate effect of reset in the middle of a high phase.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

  localparam int CODE_W = 3;

  // Half of the A divide ratio for each code; unlisted codes fall back to /64.
  function automatic int unsigned half_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'b000:  return 1;
      3'b100:  return 2;
      3'b010:  return 4;
      3'b110:  return 8;
      3'b001:  return 16;
      3'b101:  return 32;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/postdiv_sync.sv
module postdiv_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/postdiv_ratio_ctr.sv
module postdiv_ratio_ctr
  import postdiv_pkg::*;
#(
  parameter int MAX_RATIO = 64,
  localparam int CNT_W    = $clog2(MAX_RATIO)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              a_raw,
  output logic              wrap
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] half_new;

  assign half_new = CNT_W'(half_ratio(code));
  assign last_idx = {half_q[CNT_W-2:0], 1'b0} - CNT_W'(1);
  assign wrap     = (cnt == last_idx);
  assign a_raw    = (cnt < half_q);

  // Reset parks the counter on a wrap so the first edge loads the code.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= CNT_W'(1);
      half_q <= CNT_W'(1);
    end else if (wrap) begin
      cnt    <= '0;
      half_q <= half_new;
    end else begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

  // R9
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(half_q));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx);

endmodule

// File: rtl/postdiv_b_phase.sv
module postdiv_b_phase (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic a_raw,
  input  logic nb,
  output logic b_raw,
  output logic b_bound,
  output logic nb_act
);

  logic bph;

  // A B period ends at every A wrap in same-rate mode, else after its low half.
  assign b_bound = wrap & (~nb_act | ~bph);
  assign b_raw   = nb_act ? bph : a_raw;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bph    <= 1'b0;
      nb_act <= 1'b0;
    end else begin
      if (wrap)    bph    <= ~bph;
      if (b_bound) nb_act <= nb;
    end
  end

  // R4
  b_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(bph));

endmodule

// File: rtl/postdiv_gate.sv
module postdiv_gate (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic bound,
  input  logic run_s,
  output logic q,
  output logic en
);

  // The enable moves only on the last (low) cycle of a period.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      en <= 1'b0;
      q  <= 1'b0;
    end else begin
      if (bound) en <= run_s;
      q <= raw & en;
    end
  end

  // R7
  gate_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !bound |=> $stable(en));

endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import postdiv_pkg::*;
#(
  parameter int MAX_RATIO   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              b_half,
  input  logic              run_a,
  input  logic              run_b,
  output logic              clk_a,
  output logic              clk_b
);

  localparam int NCH = 2;

  logic           a_raw, a_wrap;
  logic           b_raw, b_bound, nb_act;
  logic [NCH-1:0] raw_v, bound_v, run_s, out_v, en_v;

  postdiv_ratio_ctr #(.MAX_RATIO(MAX_RATIO)) u_ctr (
    .clk(clk), .rst(rst), .code(ratio_code), .a_raw(a_raw), .wrap(a_wrap)
  );

  postdiv_b_phase u_bph (
    .clk(clk), .rst(rst), .wrap(a_wrap), .a_raw(a_raw), .nb(b_half),
    .b_raw(b_raw), .b_bound(b_bound), .nb_act(nb_act)
  );

  postdiv_sync #(.STAGES(SYNC_STAGES), .WIDTH(NCH)) u_sync (
    .clk(clk), .rst(rst), .d({run_b, run_a}), .q(run_s)
  );

  assign raw_v   = {b_raw, a_raw};
  assign bound_v = {b_bound, a_wrap};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    postdiv_gate u_gate (
      .clk(clk), .rst(rst), .raw(raw_v[g]), .bound(bound_v[g]),
      .run_s(run_s[g]), .q(out_v[g]), .en(en_v[g])
    );
  end

  assign clk_a = out_v[0];
  assign clk_b = out_v[1];

  // R5
  b_edge_align_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_b) && $past(en_v[0])) |-> $rose(clk_a));

  // R4
  same_rate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!nb_act) && $past(en_v[0]) && $past(en_v[1])) |-> (clk_a == clk_b));

endmodule

// File: tb/test_clk_postdiv.sv
`timescale 1ns/1ps
module test_clk_postdiv;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio_code = 3'b000;
  logic       b_half = 1'b0;
  logic       run_a = 1'b0;
  logic       run_b = 1'b0;
  logic       clk_a, clk_b;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  clk_postdiv i_clk_postdiv (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .b_half(b_half),
    .run_a(run_a), .run_b(run_b), .clk_a(clk_a), .clk_b(clk_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitors: coincidence of B rises with A rises, and A phase lengths
  bit coin_en = 1'b0;
  int coin_bad = 0;
  bit run_chk = 1'b0;
  int ok_h1 = 1, ok_h2 = 1;
  int run_bad = 0;
  int hi_len = 0, lo_len = 0;
  logic pa = 1'b0, pb = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (coin_en && !pb && clk_b && !(!pa && clk_a)) coin_bad++;
      if (pa && !clk_a) begin
        if (run_chk && hi_len != ok_h1 && hi_len != ok_h2) run_bad++;
        hi_len = 0;
      end
      if (!pa && clk_a) begin
        if (run_chk && lo_len != ok_h1 && lo_len != ok_h2) run_bad++;
        lo_len = 0;
      end
      if (clk_a) hi_len++; else lo_len++;
    end
    pa = clk_a;
    pb = clk_b;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Period and high count in source cycles, rise to rise
  task automatic period_of(input bit sel_b, output int per, output int hi);
    logic v, pv;
    int guard;
    guard = 0;
    per = 0;
    hi = 0;
    pv = sel_b ? clk_b : clk_a;
    forever begin
      @(negedge clk);
      v = sel_b ? clk_b : clk_a;
      if (!pv && v) break;
      pv = v;
      guard++;
      if (guard > 1000) return;
    end
    forever begin
      per++;
      if (v) hi++;
      @(negedge clk);
      pv = v;
      v = sel_b ? clk_b : clk_a;
      if (!pv && v) break;
      if (per > 1000) return;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    run_a = 1'b1;
    run_b = 1'b1;
    wait_cyc(5);
    check("R10 reset A low", clk_a, 0);
    check("R10 reset B low", clk_b, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_ratios();
    int per, hi;
    logic [2:0] codes [8] = '{3'b000, 3'b100, 3'b010, 3'b110,
                              3'b001, 3'b101, 3'b011, 3'b111};
    int exp_r [8] = '{2, 4, 8, 16, 32, 64, 64, 64};
    b_half = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ratio_code = codes[i];
      wait_cyc(160);
      period_of(1'b0, per, hi);
      if (i < 6) check("R1 A period", per, exp_r[i]);
      else       check("R2 fallback period", per, exp_r[i]);
      check("R3 A high phase", hi, exp_r[i] / 2);
      period_of(1'b1, per, hi);
      check("R4 B same-rate period", per, exp_r[i]);
    end
  endtask

  task automatic t_half_b();
    int per, hi;
    ratio_code = 3'b100;
    b_half = 1'b1;
    wait_cyc(160);
    coin_bad = 0;
    coin_en = 1'b1;
    period_of(1'b1, per, hi);
    check("R4 B half-rate period", per, 8);
    check("R4 B half-rate high", hi, 4);
    wait_cyc(100);
    coin_en = 1'b0;
    check("R5 B rises without A", coin_bad, 0);
  endtask

  task automatic t_stop_start();
    int per, hi, lat, highs;
    ratio_code = 3'b010;
    b_half = 1'b0;
    wait_cyc(100);
    run_a = 1'b0;
    wait_cyc(8 + 4);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_a) highs++;
    end
    check("R6 R8 A held low", highs, 0);
    period_of(1'b1, per, hi);
    check("R6 B runs while A stopped", per, 8);
    run_a = 1'b1;
    lat = 0;
    while (!clk_a && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R8 start latency bound", int'(lat <= 8 + 4), 1);
    hi = 0;
    while (clk_a && hi < 200) begin
      @(negedge clk);
      hi++;
    end
    check("R7 first pulse full", hi, 4);
    // restart both together at half rate: A may lead, but B never rises alone
    b_half = 1'b1;
    run_a = 1'b0;
    run_b = 1'b0;
    wait_cyc(40);
    check("R6 both stopped B", clk_b, 0);
    coin_bad = 0;
    coin_en = 1'b1;
    run_a = 1'b1;
    run_b = 1'b1;
    wait_cyc(120);
    coin_en = 1'b0;
    check("R5 R7 aligned after restart", coin_bad, 0);
    b_half = 1'b0;
  endtask

  task automatic t_ratio_change();
    ratio_code = 3'b000;
    wait_cyc(140);
    ok_h1 = 1;
    ok_h2 = 32;
    run_bad = 0;
    run_chk = 1'b1;
    wait_cyc(3);
    ratio_code = 3'b101;
    wait_cyc(300);
    ratio_code = 3'b000;
    wait_cyc(150);
    run_chk = 1'b0;
    check("R9 no shortened A phase", run_bad, 0);
  endtask

  task automatic t_async_reset();
    int guard;
    ratio_code = 3'b110;
    wait_cyc(40);
    guard = 0;
    while (!clk_a && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    #1;
    rst = 1'b1;
    #0.5;
    check("R10 async A forced low", clk_a, 0);
    check("R10 async B forced low", clk_b, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_half_b();
    t_stop_start();
    t_ratio_change();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule